// File: doc/BRIEF.md
# Periodic Thermal Threshold Monitor

This block sequences an abstract temperature-sensing ADC. While automatic scanning is on, it waits a programmed number of timebase strobes, converts every enabled channel once in ascending channel order, stores each 12-bit result, and compares it with two per-channel limits: an interrupt limit and a shutdown limit. The ADC code drops as the die heats up, so a sample is over a limit when its code is below that limit.

Consecutive over-limit samples are counted per channel and per limit. When the count reaches the programmed debounce value, the interrupt limit sets a per-channel pending bit and the shutdown limit trips one or both shutdown outputs. One output is a chip-reset request. The other is a pin whose active level is programmable. Both shutdown outputs stay tripped until reset. Once any channel's last sample was over either limit, the gap between scans switches from the normal period to a shorter hot period.

Software programs and reads the block through a simple address/write/read-data port. The ADC is driven by a request that is held until a one-cycle done pulse returns the result.

Top module: `thermal_scan_ctl`

## Requirements
- R1: After reset, both debounce registers (0x60 interrupt, 0x64 shutdown) read 4, every data register reads 0, irq and shut_rst are 0, and shut_pin is 1 (active-low idle).
- R2: Register offsets: control 0x04, enable/route 0x08, pending 0x0C, data 0x20+4*ch, interrupt limit 0x30+4*ch, shutdown limit 0x40+4*ch, normal period 0x68, hot period 0x6C. Written values read back.
- R3: Control bit 0 enables scanning, and bit 4+ch selects channel ch. A scan converts the selected channels in ascending order, one request per channel, with adc_ch equal to the channel and held until adc_done. Unselected channels are never converted.
- R4: A data register reads 0 until its channel's first conversion completes. After that it reads the latest 12-bit result.
- R5: Strobes on tick are counted only between scans. A scan starts on the strobe that completes the period: the normal period (0x68) when no channel's last sample was below either of its limits, otherwise the hot period (0x6C). A period of 0 or 1 scans on every strobe.
- R6: Pending bit ch is set on the sample that brings the run of consecutive samples below the channel's interrupt limit up to the interrupt debounce count. A sample that is not below the limit restarts the run from zero.
- R7: Writing 1 to a pending bit at 0x0C clears it, and a set in the same cycle wins. irq is the OR of the pending bits whose enable bit ch at 0x08 is 1.
- R8: When the run of samples below the shutdown limit reaches the shutdown debounce count, the pin output trips if bit 4+ch at 0x08 is set, and shut_rst trips if bit 8+ch is set. Both stay tripped until reset.
- R9: Control bit 8 sets the pin polarity. With 1 the pin is high when tripped, and with 0 it is low when tripped.
- R10: Clearing control bit 0 starts no new conversion after the current one ends. Stored data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timebase strobe that the period registers count |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| adc_req | output | 1 | Conversion request, held until adc_done |
| adc_ch | output | 2 | Channel being converted |
| adc_done | input | 1 | One-cycle end-of-conversion pulse |
| adc_data | input | 12 | Conversion result, valid with adc_done |
| irq | output | 1 | Interrupt request |
| shut_pin | output | 1 | Shutdown pin, polarity per control bit 8 |
| shut_rst | output | 1 | Chip-reset request, tripped state |

## Verification
The assertions assume the ADC pulses adc_done for one cycle, only while adc_req is high, and never twice for one request. They also assume the bus only writes to addresses in the register map. The bench's ADC model answers each request after a fixed latency with a single done pulse carrying the code chosen for that channel. The bench never writes an unmapped address.

// File: rtl/thermal_scan_ctl.sv
module thermal_scan_ctl #(
  parameter int NCH = 3,
  parameter int DW  = 12,
  parameter int CW  = 8,
  parameter int PW  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic [7:0]     bus_addr,
  input  logic           bus_wr,
  input  logic [PW-1:0]  bus_wdata,
  output logic [PW-1:0]  bus_rdata,
  output logic           adc_req,
  output logic [CHW-1:0] adc_ch,
  input  logic           adc_done,
  input  logic [DW-1:0]  adc_data,
  output logic           irq,
  output logic           shut_pin,
  output logic           shut_rst
);
  logic [8:0]     ctrl_q;
  logic [11:0]    ien_q;
  logic [NCH-1:0] pend_q, over_q;
  logic [DW-1:0]  data_q [NCH];
  logic [DW-1:0]  icmp_q [NCH];
  logic [DW-1:0]  scmp_q [NCH];
  logic [CW-1:0]  ic_q [NCH];
  logic [CW-1:0]  sc_q [NCH];
  logic [CW-1:0]  idb_q, sdb_q;
  logic [PW-1:0]  per_q, perht_q, cnt_q;
  logic           busy_q, pin_l, rst_l;
  logic [CHW-1:0] cur_q;

  function automatic logic [CHW:0] first_at(input logic [NCH-1:0] m, input int from);
    logic [CHW:0] r;
    r = '0;
    for (int k = NCH - 1; k >= 0; k--)
      if (m[k] && k >= from) r = {1'b1, CHW'(k)};
    return r;
  endfunction

  wire            en     = ctrl_q[0];
  wire [NCH-1:0]  src    = ctrl_q[4 +: NCH];
  wire [CHW:0]    nxt    = first_at(src, int'(cur_q) + 1);
  wire [CHW:0]    first  = first_at(src, 0);
  wire [PW-1:0]   per_sel = (|over_q) ? perht_q : per_q;
  wire            io     = adc_data < icmp_q[cur_q];
  wire            so     = adc_data < scmp_q[cur_q];
  wire [CW-1:0]   ic_inc = (&ic_q[cur_q]) ? ic_q[cur_q] : ic_q[cur_q] + 1'b1;
  wire [CW-1:0]   sc_inc = (&sc_q[cur_q]) ? sc_q[cur_q] : sc_q[cur_q] + 1'b1;
  wire            smp    = busy_q && adc_done;
  wire [NCH-1:0]  pset   = (smp && io && ic_inc >= idb_q) ? (NCH'(1) << cur_q) : '0;
  wire [NCH-1:0]  pclr   = (bus_wr && bus_addr == 8'h0C) ? bus_wdata[NCH-1:0] : '0;
  wire            strip  = smp && so && sc_inc >= sdb_q;

  assign adc_req  = busy_q;
  assign adc_ch   = cur_q;
  assign irq      = |(pend_q & ien_q[NCH-1:0]);
  assign shut_pin = ctrl_q[8] ? pin_l : ~pin_l;
  assign shut_rst = rst_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; ien_q <= '0; pend_q <= '0; over_q <= '0;
      idb_q <= CW'(4); sdb_q <= CW'(4);
      per_q <= '0; perht_q <= '0; cnt_q <= '0;
      busy_q <= 1'b0; cur_q <= '0; pin_l <= 1'b0; rst_l <= 1'b0;
      for (int c = 0; c < NCH; c++) begin
        data_q[c] <= '0; icmp_q[c] <= '0; scmp_q[c] <= '0;
        ic_q[c] <= '0; sc_q[c] <= '0;
      end
    end else begin
      if (busy_q) begin
        if (adc_done) begin
          data_q[cur_q] <= adc_data;
          over_q[cur_q] <= io | so;
          ic_q[cur_q]   <= io ? ic_inc : '0;
          sc_q[cur_q]   <= so ? sc_inc : '0;
          if (strip && ien_q[4 + int'(cur_q)]) pin_l <= 1'b1;
          if (strip && ien_q[8 + int'(cur_q)]) rst_l <= 1'b1;
          if (en && nxt[CHW]) cur_q <= nxt[CHW-1:0];
          else busy_q <= 1'b0;
        end
      end else if (!en) begin
        cnt_q <= '0;
      end else if (tick) begin
        if (({1'b0, cnt_q} + 1'b1) >= {1'b0, per_sel}) begin
          cnt_q <= '0;
          if (first[CHW]) begin
            busy_q <= 1'b1;
            cur_q  <= first[CHW-1:0];
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      pend_q <= (pend_q & ~pclr) | pset;
      if (bus_wr) begin
        case (bus_addr)
          8'h04: ctrl_q  <= bus_wdata[8:0];
          8'h08: ien_q   <= bus_wdata[11:0];
          8'h60: idb_q   <= bus_wdata[CW-1:0];
          8'h64: sdb_q   <= bus_wdata[CW-1:0];
          8'h68: per_q   <= bus_wdata;
          8'h6C: perht_q <= bus_wdata;
          default: ;
        endcase
        for (int c = 0; c < NCH; c++) begin
          if (bus_addr == 8'(8'h30 + 4 * c)) icmp_q[c] <= bus_wdata[DW-1:0];
          if (bus_addr == 8'(8'h40 + 4 * c)) scmp_q[c] <= bus_wdata[DW-1:0];
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      8'h04: bus_rdata = PW'(ctrl_q);
      8'h08: bus_rdata = PW'(ien_q);
      8'h0C: bus_rdata = PW'(pend_q);
      8'h60: bus_rdata = PW'(idb_q);
      8'h64: bus_rdata = PW'(sdb_q);
      8'h68: bus_rdata = per_q;
      8'h6C: bus_rdata = perht_q;
      default: ;
    endcase
    for (int c = 0; c < NCH; c++) begin
      if (bus_addr == 8'(8'h20 + 4 * c)) bus_rdata = PW'(data_q[c]);
      if (bus_addr == 8'(8'h30 + 4 * c)) bus_rdata = PW'(icmp_q[c]);
      if (bus_addr == 8'(8'h40 + 4 * c)) bus_rdata = PW'(scmp_q[c]);
    end
  end
endmodule

// File: rtl/thermal_scan_chk.sv
module thermal_scan_chk #(
  parameter int NCH = 3,
  parameter int CHW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_wr,
  input logic [7:0]     bus_addr,
  input logic           adc_req,
  input logic           adc_done,
  input logic [CHW-1:0] adc_ch,
  input logic           en,
  input logic [NCH-1:0] pend,
  input logic           pin_l,
  input logic           shut_rst
);
  a_r3_hold_ch: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_req && !adc_done) |=> (adc_req && $stable(adc_ch)));
  a_r3_ch_range: assert property (@(posedge clk) disable iff (!rst_n)
    adc_req |-> (int'(adc_ch) < NCH));
  a_r10_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !adc_req) |=> !adc_req);
  a_r8_rst_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    shut_rst |=> shut_rst);
  a_r8_pin_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    pin_l |=> pin_l);
  a_r7_pend_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == 8'h0C) |=> ((pend & $past(pend)) == $past(pend)));
endmodule

bind thermal_scan_ctl thermal_scan_chk #(.NCH(NCH), .CHW(CHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .adc_req(adc_req), .adc_done(adc_done), .adc_ch(adc_ch),
  .en(ctrl_q[0]), .pend(pend_q), .pin_l(pin_l), .shut_rst(shut_rst)
);

// File: tb/sim_thermal_scan_ctl.sv
`timescale 1ns/1ps
module sim_thermal_scan_ctl;
  logic clk = 0, rst_n = 0, tick = 0, bus_wr = 0, adc_done = 0;
  logic [7:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic [11:0] adc_data = 0;
  logic [1:0]  adc_ch;
  logic adc_req, irq, shut_pin, shut_rst;
  int errors = 0, checks = 0, cyc = 0, tcnt = 0, lat = -1;
  int code [3];
  bit started = 0;

  int m_ctrl, m_ien, m_pend, m_idb, m_sdb, m_per, m_perht, m_busy, m_cur, m_cnt, m_pinl, m_rstl;
  int m_data[3], m_icmp[3], m_scmp[3], m_ic[3], m_sc[3], m_over[3], m_ns[3];

  thermal_scan_ctl u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .adc_req(adc_req),
    .adc_ch(adc_ch), .adc_done(adc_done), .adc_data(adc_data), .irq(irq),
    .shut_pin(shut_pin), .shut_rst(shut_rst));

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tick = (tcnt == 3);
    tcnt = (tcnt + 1) % 4;
    adc_done = 0;
    if (adc_req) begin
      if (lat < 0) lat = 2;
      else if (lat == 0) begin adc_done = 1; adc_data = 12'(code[adc_ch]); lat = -1; end
      else lat--;
    end else lat = -1;
  end

  always @(posedge clk) begin
    int c, d, io, so, setp, clr, nxt, per;
    if (!rst_n) begin
      m_ctrl = 0; m_ien = 0; m_pend = 0; m_idb = 4; m_sdb = 4; m_per = 0; m_perht = 0;
      m_busy = 0; m_cur = 0; m_cnt = 0; m_pinl = 0; m_rstl = 0;
      for (int k = 0; k < 3; k++) begin
        m_data[k] = 0; m_icmp[k] = 0; m_scmp[k] = 0; m_ic[k] = 0; m_sc[k] = 0; m_over[k] = 0; m_ns[k] = 0;
      end
    end else begin
      setp = 0;
      if (m_busy != 0) begin
        if (adc_done) begin
          c = m_cur; d = int'(adc_data);
          io = (d < m_icmp[c]) ? 1 : 0; so = (d < m_scmp[c]) ? 1 : 0;
          m_over[c] = io | so; m_data[c] = d; m_ns[c]++;
          if (io != 0) begin
            if (m_ic[c] < 255) m_ic[c]++;
            if (m_ic[c] >= m_idb) setp = setp | (1 << c);
          end else m_ic[c] = 0;
          if (so != 0) begin
            if (m_sc[c] < 255) m_sc[c]++;
            if (m_sc[c] >= m_sdb) begin
              if (((m_ien >> (4 + c)) & 1) != 0) m_pinl = 1;
              if (((m_ien >> (8 + c)) & 1) != 0) m_rstl = 1;
            end
          end else m_sc[c] = 0;
          nxt = -1;
          for (int k = c + 1; k < 3; k++) if (nxt < 0 && ((m_ctrl >> (4 + k)) & 1) != 0) nxt = k;
          if ((m_ctrl & 1) != 0 && nxt >= 0) m_cur = nxt; else m_busy = 0;
        end
      end else if ((m_ctrl & 1) == 0) m_cnt = 0;
      else if (tick) begin
        per = (m_over[0] | m_over[1] | m_over[2]) != 0 ? m_perht : m_per;
        if (m_cnt + 1 >= per) begin
          m_cnt = 0; nxt = -1;
          for (int k = 0; k < 3; k++) if (nxt < 0 && ((m_ctrl >> (4 + k)) & 1) != 0) nxt = k;
          if (nxt >= 0) begin m_busy = 1; m_cur = nxt; end
        end else m_cnt++;
      end
      clr = (bus_wr && bus_addr == 8'h0C) ? int'(bus_wdata) & 7 : 0;
      m_pend = (m_pend & ~clr) | setp;
      if (bus_wr) begin
        case (bus_addr)
          8'h04: m_ctrl = int'(bus_wdata) & 'h1ff;
          8'h08: m_ien = int'(bus_wdata) & 'hfff;
          8'h60: m_idb = int'(bus_wdata) & 'hff;
          8'h64: m_sdb = int'(bus_wdata) & 'hff;
          8'h68: m_per = int'(bus_wdata);
          8'h6C: m_perht = int'(bus_wdata);
          default: ;
        endcase
        for (int k = 0; k < 3; k++) begin
          if (int'(bus_addr) == 'h30 + 4 * k) m_icmp[k] = int'(bus_wdata) & 'hfff;
          if (int'(bus_addr) == 'h40 + 4 * k) m_scmp[k] = int'(bus_wdata) & 'hfff;
        end
      end
    end
  end

  always @(negedge clk) begin
    int ei, ep;
    if (started) begin
      checks++;
      ei = ((m_pend & m_ien & 7) != 0) ? 1 : 0;
      ep = (((m_ctrl >> 8) & 1) != 0) ? m_pinl : 1 - m_pinl;
      if (int'(adc_req) != m_busy || (adc_req && int'(adc_ch) != m_cur) || int'(irq) != ei
          || int'(shut_pin) != ep || int'(shut_rst) != m_rstl) begin
        errors++;
        $display("FAIL R3,R5,R6,R7,R8,R9 cycle %0d: req/ch/irq/pin/rst act %0d/%0d/%0d/%0d/%0d exp %0d/%0d/%0d/%0d/%0d",
          cyc, adc_req, adc_ch, irq, shut_pin, shut_rst, m_busy, m_cur, ei, ep, m_rstl);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  function automatic int model_read(input int a);
    case (a)
      'h04: return m_ctrl; 'h08: return m_ien; 'h0C: return m_pend;
      'h60: return m_idb; 'h64: return m_sdb; 'h68: return m_per; 'h6C: return m_perht;
      default: ;
    endcase
    for (int k = 0; k < 3; k++) begin
      if (a == 'h20 + 4 * k) return m_data[k];
      if (a == 'h30 + 4 * k) return m_icmp[k];
      if (a == 'h40 + 4 * k) return m_scmp[k];
    end
    return 0;
  endfunction

  task automatic wr(input int a, input int v);
    @(negedge clk); bus_addr = 8'(a); bus_wdata = 16'(v); bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd_chk(input int a, input int exp, input string tag);
    @(negedge clk); bus_addr = 8'(a); #1;
    checks++;
    if (int'(bus_rdata) != exp) begin
      errors++;
      $display("FAIL %s addr %h: act %0d exp %0d", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic rd_model(input int a, input string tag);
    int e;
    @(negedge clk); bus_addr = 8'(a); #1;
    e = model_read(a);
    checks++;
    if (int'(bus_rdata) != e) begin
      errors++;
      $display("FAIL %s addr %h: act %0d exp %0d", tag, a, bus_rdata, e);
    end
  endtask

  task automatic pin_chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin errors++; $display("FAIL %s: act %0d exp %0d", tag, act, exp); end
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int n;
    for (int k = 0; k < 3; k++) code[k] = 3700;
    run(3); rst_n = 1; started = 1;
    // R1 reset state
    rd_chk('h60, 4, "R1 idb"); rd_chk('h64, 4, "R1 sdb"); rd_chk('h24, 0, "R1 data");
    pin_chk(shut_pin, 1, "R1 shut_pin"); pin_chk(shut_rst, 0, "R1 shut_rst"); pin_chk(irq, 0, "R1 irq");
    wr('h34, 3600); wr('h38, 3600); wr('h44, 3500); wr('h48, 3500);
    wr('h68, 5); wr('h6C, 2); wr('h64, 3);
    wr('h08, 'h426);
    rd_chk('h34, 3600, "R2 icmp1"); rd_chk('h08, 'h426, "R2 ien");
    rd_chk('h6C, 2, "R2 perht");
    rd_chk('h24, 0, "R4 before conversion");
    wr('h04, 'h061);
    rd_chk('h04, 'h061, "R2 ctrl");
    run(200);
    rd_chk('h24, 3700, "R4 data ch1"); rd_chk('h28, 3700, "R4 data ch2");
    rd_chk('h20, 0, "R3 ch0 unselected");
    // R6 interrupt debounce on ch1
    code[1] = 3550;
    wait (m_pend == 2); @(negedge clk);
    rd_chk('h0C, 2, "R6 pending ch1");
    pin_chk(irq, 1, "R6 irq");
    // R6 run restart on ch2
    code[2] = 3550;
    wait (m_ic[2] == 3); @(negedge clk);
    code[2] = 3700; n = m_ns[2];
    wait (m_ns[2] == n + 1); @(negedge clk);
    code[2] = 3550;
    wait (m_ic[2] == 3); @(negedge clk);
    code[2] = 3700;
    rd_chk('h0C, 2, "R6 broken run keeps ch2 clear");
    // R7 enable gating and W1C
    wr('h08, 'h424); run(2);
    pin_chk(irq, 0, "R7 irq masked");
    wr('h08, 'h426);
    code[1] = 3700; n = m_ns[1];
    wait (m_ns[1] == n + 1); @(negedge clk);
    wr('h0C, 2); run(2);
    rd_chk('h0C, 0, "R7 W1C");
    pin_chk(irq, 0, "R7 irq cleared");
    // R8 shutdown routed to pin on ch1
    code[1] = 3400;
    wait (m_pinl == 1); run(2);
    pin_chk(shut_pin, 0, "R8 pin tripped active low");
    pin_chk(shut_rst, 0, "R8 reset not routed for ch1");
    wr('h04, 'h161); run(2);
    pin_chk(shut_pin, 1, "R9 pin active high");
    code[2] = 3400;
    wait (m_rstl == 1); run(2);
    pin_chk(shut_rst, 1, "R8 reset request");
    code[1] = 3700; code[2] = 3700;
    run(300);
    pin_chk(shut_rst, 1, "R8 reset latched"); pin_chk(shut_pin, 1, "R8 pin latched");
    rd_model('h0C, "R6 pending after cool");
    // R10 disable
    wr('h04, 'h160); run(100);
    pin_chk(adc_req, 0, "R10 no request");
    rd_chk('h24, 3700, "R10 data kept");
    run(100);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule